// File: doc/BRIEF.md
# Pre-trigger capture sample FIFO

This block buffers three-axis samples (three signed 16-bit words per entry) in a 32-entry circular store. A mode input selects one of four behaviours. Bypass stores nothing and empties the buffer. Queue mode keeps samples until the buffer is full and then drops new ones. Stream mode keeps the newest samples by overwriting the oldest. Capture mode overwrites the oldest sample while it waits for a trigger. When the trigger arrives, the buffer keeps only the newest `n` entries, raises an interrupt, and then behaves like queue mode.

After one trigger has been taken, capture mode is disarmed. It is armed again only when the mode goes from bypass directly into capture. The user therefore reads out the captured history, passes through bypass, and re-enters capture to take the next event. The oldest entry is always shown on the head outputs. The pop input removes that entry.

Top module: `cap_fifo`

## Requirements
- R1: During reset and right after it, `level` is 0 and both interrupt outputs are low.
- R2: In queue mode (`mode`=1), each accepted sample is stored. `head_*` shows the oldest stored sample and `level` gives the entry count, both one clock edge after the strobe. Each accepted pop removes the oldest entry.
- R3: In queue mode with 32 entries stored, a new sample with no pop in the same cycle is dropped. `level` stays 32 and the head is unchanged.
- R4: In stream mode (`mode`=2) with 32 entries stored, a new sample replaces the oldest entry. `level` stays 32 and the head moves to the next-oldest sample.
- R5: Bypass mode (`mode`=0) sets `level` to 0 at the next edge, disarms capture and clears the interrupt.
- R6: In capture mode (`mode`=3), while armed, the buffer keeps the latest 32 samples and overwrites the oldest when it is full.
- R7: An accepted trigger keeps only the newest min(`keep_n`, `level`) entries, and the oldest kept entry becomes the head.
- R8: After the trigger, capture mode stores a sample only while fewer than 32 entries are held. Otherwise the sample is dropped.
- R9: An accepted trigger sets an interrupt level that stays high until bypass. It appears on `irq_a` when `irq_sel`=0 and on `irq_b` when `irq_sel`=1.
- R10: A trigger is accepted only while armed. Arming happens only in the cycle after the mode changes from bypass to capture. A second trigger, or capture entered from queue or stream mode, changes nothing.
- R11: A pop with `level`=0 is ignored. In the cycle a trigger is accepted, any sample strobe or pop in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 bypass, 1 queue, 2 stream, 3 capture |
| smp_valid | input | 1 | New sample strobe |
| smp_x | input | 16 | Signed X word |
| smp_y | input | 16 | Signed Y word |
| smp_z | input | 16 | Signed Z word |
| keep_n | input | 6 | Entries kept after a trigger |
| irq_sel | input | 1 | Interrupt routing: 0 to irq_a, 1 to irq_b |
| trig | input | 1 | Trigger pulse |
| pop | input | 1 | Remove the oldest entry |
| head_x | output | 16 | X word of the oldest entry |
| head_y | output | 16 | Y word of the oldest entry |
| head_z | output | 16 | Z word of the oldest entry |
| level | output | 6 | Number of stored entries |
| irq_a | output | 1 | Trigger interrupt, first line |
| irq_b | output | 1 | Trigger interrupt, second line |

## Verification
The block has a single register stage, so `level`, the head words and the interrupt lines all take their new values at the first rising edge after a strobe, trigger, pop or mode change. The bench applies each stimulus on a falling edge and updates its reference queue at the following rising edge. It compares the outputs at the next falling edge, half a period later and well clear of the edge. The head words are compared only while the reference queue holds at least one entry.

// File: rtl/cap_fifo_pkg.sv
package cap_fifo_pkg;

    localparam int unsigned AXIS_W     = 16;
    localparam int unsigned FIFO_DEPTH = 32;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_QUEUE  = 2'd1,
        MODE_STREAM = 2'd2,
        MODE_TRIG   = 2'd3
    } fifo_mode_e;

    typedef struct packed {
        logic signed [AXIS_W-1:0] x;
        logic signed [AXIS_W-1:0] y;
        logic signed [AXIS_W-1:0] z;
    } axis_sample_t;

    // Smaller of two unsigned counts.
    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cap_fifo_store.sv
module cap_fifo_store
    import cap_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_ptr,
    input  axis_sample_t    wr_data,
    input  logic [AW-1:0]   rd_ptr,
    output axis_sample_t    rd_data
);

    axis_sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/cap_fifo_ctrl.sv
module cap_fifo_ctrl
    import cap_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  fifo_mode_e      mode,
    input  logic            smp_valid,
    input  logic            pop,
    input  logic            trig,
    input  logic [CW-1:0]   keep_n,
    output logic            wr_en,
    output logic [AW-1:0]   wr_ptr,
    output logic [AW-1:0]   rd_ptr,
    output logic [CW-1:0]   count,
    output logic            trig_flag
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    fifo_mode_e    prev_mode;
    logic          armed;
    logic          is_byp, full, trig_ok, overwrite;
    logic          pop_ok, push_ok, drop_old, adv_rd;
    logic [CW-1:0] keep;

    always_comb begin
        is_byp    = (mode == MODE_BYPASS);
        full      = (count == FULL_CNT);
        trig_ok   = (mode == MODE_TRIG) && armed && trig;
        overwrite = (mode == MODE_STREAM) || ((mode == MODE_TRIG) && armed);
        pop_ok    = pop && (count != '0);
        push_ok   = smp_valid && (!full || pop_ok || overwrite);
        drop_old  = push_ok && full && !pop_ok;
        adv_rd    = pop_ok || drop_old;
        keep      = (keep_n < count) ? keep_n : count;
        wr_en     = push_ok && !is_byp && !trig_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            armed     <= 1'b0;
            trig_flag <= 1'b0;
            prev_mode <= MODE_BYPASS;
        end else begin
            prev_mode <= mode;
            if (is_byp) begin
                wr_ptr    <= '0;
                rd_ptr    <= '0;
                count     <= '0;
                armed     <= 1'b0;
                trig_flag <= 1'b0;
            end else if (trig_ok) begin
                rd_ptr    <= wr_ptr - keep[AW-1:0];
                count     <= keep;
                armed     <= 1'b0;
                trig_flag <= 1'b1;
            end else begin
                if (push_ok) wr_ptr <= wr_ptr + 1'b1;
                if (adv_rd)  rd_ptr <= rd_ptr + 1'b1;
                count <= count + CW'(push_ok) - CW'(adv_rd);
                if ((mode == MODE_TRIG) && (prev_mode == MODE_BYPASS)) begin
                    armed <= 1'b1;
                end
            end
        end
    end

    // Occupancy never exceeds the depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // Queue mode drops a sample that arrives when full
    assert_queue_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUEUE && full && smp_valid && !pop) |=> (count == FULL_CNT) && $stable(rd_ptr));

    // Stream mode stays full and moves past the oldest entry
    assert_stream_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STREAM && full && smp_valid && !pop) |=> (count == FULL_CNT) && (rd_ptr == $past(rd_ptr) + 1'b1));

    // Bypass empties the buffer
    assert_bypass_clear_R5: assert property (@(posedge clk) disable iff (rst)
        is_byp |=> (count == '0) && !trig_flag);

    // Trigger trims and disarms
    assert_trim_disarm_R7: assert property (@(posedge clk) disable iff (rst)
        trig_ok |=> (count <= $past(keep_n)) && !armed && trig_flag);

    // A disarmed trigger changes nothing
    assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRIG && !armed && trig && !smp_valid && !pop) |=> $stable(count) && $stable(rd_ptr));

endmodule

// File: rtl/cap_fifo.sv
module cap_fifo
    import cap_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               mode,
    input  logic                     smp_valid,
    input  logic signed [AXIS_W-1:0] smp_x,
    input  logic signed [AXIS_W-1:0] smp_y,
    input  logic signed [AXIS_W-1:0] smp_z,
    input  logic [CW-1:0]            keep_n,
    input  logic                     irq_sel,
    input  logic                     trig,
    input  logic                     pop,
    output logic signed [AXIS_W-1:0] head_x,
    output logic signed [AXIS_W-1:0] head_y,
    output logic signed [AXIS_W-1:0] head_z,
    output logic [CW-1:0]            level,
    output logic                     irq_a,
    output logic                     irq_b
);

    logic          wr_en, trig_flag;
    logic [AW-1:0] wr_ptr, rd_ptr;
    axis_sample_t  in_smp, head_smp;

    assign in_smp = '{x: smp_x, y: smp_y, z: smp_z};

    cap_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (fifo_mode_e'(mode)),
        .smp_valid (smp_valid),
        .pop       (pop),
        .trig      (trig),
        .keep_n    (keep_n),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (level),
        .trig_flag (trig_flag)
    );

    cap_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (in_smp),
        .rd_ptr  (rd_ptr),
        .rd_data (head_smp)
    );

    assign head_x = head_smp.x;
    assign head_y = head_smp.y;
    assign head_z = head_smp.z;
    assign irq_a  = trig_flag && !irq_sel;
    assign irq_b  = trig_flag && irq_sel;

    // Interrupt reaches at most one line
    assert_irq_route_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_a, irq_b}));

    // Interrupt clear after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (level == '0) && !irq_a && !irq_b);

endmodule

// File: tb/tb_cap_fifo.sv
`timescale 1ns/1ps
module tb_cap_fifo;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        mode;
    logic              smp_valid, irq_sel, trig, pop;
    logic signed [15:0] smp_x, smp_y, smp_z;
    logic [5:0]        keep_n;
    logic signed [15:0] head_x, head_y, head_z;
    logic [5:0]        level;
    logic              irq_a, irq_b;

    always #2.5 clk = ~clk;

    cap_fifo dut (
        .clk(clk), .rst(rst), .mode(mode), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .keep_n(keep_n),
        .irq_sel(irq_sel), .trig(trig), .pop(pop),
        .head_x(head_x), .head_y(head_y), .head_z(head_z),
        .level(level), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Scoreboard state
    logic [47:0] exp_q[$];
    bit          m_armed, m_irq;
    logic [1:0]  m_prev;
    int          tests, fails;
    int          seq;

    function automatic logic [47:0] mk(input int i);
        logic [15:0] a, b, c;
        a = 16'(i);
        b = 16'(-i);
        c = 16'(i * 3 + 7);
        return {a, b, c};
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver side: apply the stimulus, then push/pop the expected queue at the edge
    task automatic model(input logic v, input logic [47:0] d, input logic p, input logic t);
        int keep;
        if (mode == 2'd0) begin
            exp_q.delete();
            m_armed = 0;
            m_irq   = 0;
        end else if (mode == 2'd3 && m_armed && t) begin
            keep = (int'(keep_n) < exp_q.size()) ? int'(keep_n) : exp_q.size();
            while (exp_q.size() > keep) void'(exp_q.pop_front());
            m_armed = 0;
            m_irq   = 1;
        end else begin
            if (p && exp_q.size() > 0) void'(exp_q.pop_front());
            if (v) begin
                if (exp_q.size() < 32) exp_q.push_back(d);
                else if (mode == 2'd2 || (mode == 2'd3 && m_armed)) begin
                    void'(exp_q.pop_front());
                    exp_q.push_back(d);
                end
            end
            if (mode == 2'd3 && m_prev == 2'd0) m_armed = 1;
        end
        m_prev = mode;
    endtask

    // Monitor side: compare outputs against the expected queue
    task automatic monitor(input string tag);
        chk(tag, "level", level, exp_q.size());
        if (exp_q.size() > 0) chk(tag, "head", {head_x, head_y, head_z}, exp_q[0]);
        chk(tag, "irq_a", irq_a, m_irq && !irq_sel);
        chk(tag, "irq_b", irq_b, m_irq && irq_sel);
    endtask

    task automatic step(input string tag, input logic v, input logic p, input logic t);
        logic [47:0] d;
        d = mk(seq);
        if (v) seq++;
        smp_valid = v; {smp_x, smp_y, smp_z} = d; pop = p; trig = t;
        @(posedge clk);
        model(v, d, p, t);
        @(negedge clk);
        smp_valid = 0; pop = 0; trig = 0;
        monitor(tag);
    endtask

    task automatic set_mode(input string tag, input logic [1:0] m);
        mode = m;
        step(tag, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tests = 0; fails = 0; seq = 1;
        m_armed = 0; m_irq = 0; m_prev = 2'd0;
        rst = 1; mode = 2'd0; smp_valid = 0; pop = 0; trig = 0;
        irq_sel = 0; keep_n = 6'd5; smp_x = 0; smp_y = 0; smp_z = 0;
        repeat (3) @(negedge clk);
        chk("R1", "level in reset", level, 0);
        chk("R1", "irq_a in reset", irq_a, 0);
        chk("R1", "irq_b in reset", irq_b, 0);
        rst = 0;
        step("R1", 0, 0, 0);

        // Queue mode ordering and overflow drop
        set_mode("R2", 2'd1);
        for (int i = 0; i < 3; i++) step("R2", 1, 0, 0);
        step("R2", 0, 1, 0);
        for (int i = 0; i < 30; i++) step("R2", 1, 0, 0);
        for (int i = 0; i < 3; i++) step("R3", 1, 0, 0);
        step("R3", 1, 1, 0);
        for (int i = 0; i < 33; i++) step("R2", 0, 1, 0);
        step("R11", 0, 1, 0);

        // Stream mode overwrite
        set_mode("R5", 2'd0);
        set_mode("R4", 2'd2);
        for (int i = 0; i < 36; i++) step("R4", 1, 0, 0);
        set_mode("R5", 2'd0);

        // Capture mode, interrupt on second line
        irq_sel = 1; keep_n = 6'd5;
        set_mode("R10", 2'd3);
        for (int i = 0; i < 40; i++) step("R6", 1, 0, 0);
        step("R7", 1, 1, 1);
        step("R9", 0, 0, 0);
        for (int i = 0; i < 30; i++) step("R8", 1, 0, 0);
        step("R10", 0, 0, 1);
        for (int i = 0; i < 33; i++) step("R8", 0, 1, 0);
        irq_sel = 0;
        step("R9", 0, 0, 0);
        set_mode("R5", 2'd0);

        // Capture with fewer entries than requested, first line
        keep_n = 6'd10;
        set_mode("R10", 2'd3);
        for (int i = 0; i < 3; i++) step("R6", 1, 0, 0);
        step("R7", 0, 0, 1);
        step("R9", 0, 0, 0);
        keep_n = 6'd32;
        set_mode("R5", 2'd0);

        // Capture entered from queue mode stays disarmed
        set_mode("R2", 2'd1);
        set_mode("R10", 2'd3);
        for (int i = 0; i < 2; i++) step("R10", 1, 0, 0);
        step("R10", 0, 0, 1);

        // Full-depth trim keeps everything
        set_mode("R5", 2'd0);
        set_mode("R10", 2'd3);
        for (int i = 0; i < 34; i++) step("R6", 1, 0, 0);
        step("R7", 0, 0, 1);
        step("R8", 1, 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule